// File: doc/BRIEF.md
# Layered Schedule Controller with Idle Insertion

This controller sequences the read side of a pipelined layered decoder. On a start pulse it captures a small configuration table. For each layer slot the table holds a layer index, a degree (the count of nonnull blocks), a list of per-block column addresses and a hazard idle count. It then walks the slots in table order. For each layer it issues one soft-output read address per cycle, one for each block. The layer order and the block order inside each layer are fixed offline, so the controller only replays them.

Between two consecutive layers the controller stalls the node processor for a number of cycles. That number is the larger of two counts. The first is the hazard idle count of the layer just finished, which covers read-after-write distance in the pipeline. The second is the degree drop to the next layer, which keeps the outputs of the two layers from overlapping. After the last slot the controller wraps to slot 0 and advances its iteration counter, and the gap from the last layer back to the first still applies. When the programmed number of iterations has been read, it pulses done and returns to idle.

Top module: `layer_sched_ctrl`

## Requirements
- R1: A synchronous reset, taken at any time, leaves busy, rd_valid, np_stall and done low and iter_cnt at 0.
- R2: A start pulse while idle captures the configuration. Slot k's index is cfg_index[k*LW +: LW], its degree is cfg_degree[k*DW +: DW], its hazard count is cfg_hazard[k*IW +: IW], and its block j column is cfg_cols[(k*MD+j)*CW +: CW]. The first read is presented in the cycle after the start edge. For a slot of degree d, the controller presents d consecutive cycles with rd_valid high, rd_addr equal to column 0 through d-1 in order, rd_layer equal to the slot index, and rd_last high only on the block d-1 cycle.
- R3: Slots run in order 0 to cfg_nlayers-1. When the computed gap is zero, the first read of the next slot follows the last read of the current slot in the very next cycle.
- R4: After a slot's last read, the controller inserts exactly G cycles with rd_valid low and np_stall high before the next slot. G is the larger of the finished slot's hazard count and the degree-drop count. A nonzero hazard count that is larger than the degree drop sets G by itself.
- R5: The degree-drop count is the current degree minus the next degree when that difference is positive, and zero otherwise. When it exceeds the hazard count, it sets G.
- R6: After the last slot, reading wraps to slot 0. iter_cnt increments at the edge that ends the last slot's final read, and the gap from the last slot to slot 0 is applied between iterations.
- R7: After the final read of iteration cfg_iters-1, no gap is inserted. In the next cycle done is high for exactly one cycle, and busy is low.
- R8: A start pulse while busy is ignored: the table is not reloaded and the read stream continues unchanged.
- R9: A table of a single slot is legal. That slot follows itself and uses its own hazard count as the gap between iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture configuration and begin, while idle |
| cfg_nlayers | input | NLW | Number of slots used (1..NL) |
| cfg_iters | input | IT | Number of iterations (at least 1) |
| cfg_index | input | NL*LW | Layer index per slot |
| cfg_degree | input | NL*DW | Degree per slot (1..MD) |
| cfg_hazard | input | NL*IW | Hazard idle count per slot |
| cfg_cols | input | NL*MD*CW | Column address per slot and block |
| rd_valid | output | 1 | Read address valid |
| rd_addr | output | CW | Soft-output column address |
| rd_layer | output | LW | Index of the layer being read |
| rd_last | output | 1 | Last block of the current layer |
| np_stall | output | 1 | Node processor stall (idle cycle) |
| busy | output | 1 | Schedule running |
| iter_cnt | output | IT | Current iteration |
| done | output | 1 | One-cycle end-of-decoding pulse |

## Verification
The assertions take the captured configuration to be legal. The slot count must be from 1 to NL, the iteration count at least 1, and every used slot's degree from 1 to MD. Under those conditions the block pointer stays below the degree and the gap covers both counts. The bench only programs tables that meet these limits. Its mid-run start pulse carries an inverted and therefore possibly illegal configuration, which must not be captured. Reset is held from time zero, so no property sees the power-up state.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_STALL = 2'd2
    } sched_state_e;

    // saturating subtraction: a - b when positive, else zero
    function automatic logic [15:0] sat_sub(logic [15:0] a, logic [15:0] b);
        return (a > b) ? (a - b) : 16'd0;
    endfunction

endpackage

// File: rtl/lsc_cfg_table.sv
module lsc_cfg_table #(
    parameter int NL = 4,
    parameter int MD = 6,
    parameter int CW = 5,
    parameter int LW = 3,
    parameter int DW = 3,
    parameter int IW = 4,
    parameter int IT = 4,
    localparam int LPW = (NL > 1) ? $clog2(NL) : 1,
    localparam int BPW = (MD > 1) ? $clog2(MD) : 1,
    localparam int NLW = $clog2(NL + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [NLW-1:0]     cfg_nlayers,
    input  logic [IT-1:0]      cfg_iters,
    input  logic [NL*LW-1:0]   cfg_index,
    input  logic [NL*DW-1:0]   cfg_degree,
    input  logic [NL*IW-1:0]   cfg_hazard,
    input  logic [NL*MD*CW-1:0] cfg_cols,
    input  logic [LPW-1:0]     cur_ptr,
    input  logic [LPW-1:0]     nxt_ptr,
    input  logic [BPW-1:0]     blk_ptr,
    output logic [LW-1:0]      cur_index,
    output logic [DW-1:0]      cur_degree,
    output logic [IW-1:0]      cur_hazard,
    output logic [CW-1:0]      cur_col,
    output logic [DW-1:0]      nxt_degree,
    output logic [NLW-1:0]     num_layers,
    output logic [IT-1:0]      num_iters
);

    logic [LW-1:0] idx_in  [NL];
    logic [DW-1:0] deg_in  [NL];
    logic [IW-1:0] haz_in  [NL];
    logic [CW-1:0] col_in  [NL][MD];

    logic [LW-1:0] idx_q   [NL];
    logic [DW-1:0] deg_q   [NL];
    logic [IW-1:0] haz_q   [NL];
    logic [CW-1:0] col_q   [NL][MD];
    logic [NLW-1:0] nl_q;
    logic [IT-1:0]  it_q;

    // unpack the flat configuration buses per slot
    for (genvar k = 0; k < NL; k++) begin : g_slot
        assign idx_in[k] = cfg_index[k*LW +: LW];
        assign deg_in[k] = cfg_degree[k*DW +: DW];
        assign haz_in[k] = cfg_hazard[k*IW +: IW];
        for (genvar j = 0; j < MD; j++) begin : g_blk
            assign col_in[k][j] = cfg_cols[(k*MD + j)*CW +: CW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nl_q <= '0;
            it_q <= '0;
            for (int k = 0; k < NL; k++) begin
                idx_q[k] <= '0;
                deg_q[k] <= '0;
                haz_q[k] <= '0;
                for (int j = 0; j < MD; j++) col_q[k][j] <= '0;
            end
        end else if (load) begin
            nl_q <= cfg_nlayers;
            it_q <= cfg_iters;
            for (int k = 0; k < NL; k++) begin
                idx_q[k] <= idx_in[k];
                deg_q[k] <= deg_in[k];
                haz_q[k] <= haz_in[k];
                for (int j = 0; j < MD; j++) col_q[k][j] <= col_in[k][j];
            end
        end
    end

    assign cur_index  = idx_q[cur_ptr];
    assign cur_degree = deg_q[cur_ptr];
    assign cur_hazard = haz_q[cur_ptr];
    assign cur_col    = col_q[cur_ptr][blk_ptr];
    assign nxt_degree = deg_q[nxt_ptr];
    assign num_layers = nl_q;
    assign num_iters  = it_q;

    // R8: without a load the captured table stays put
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(nl_q) && $stable(it_q) && $stable(deg_q[0]) && $stable(col_q[0][0])));

endmodule

// File: rtl/lsc_gap_calc.sv
module lsc_gap_calc #(
    parameter int DW = 3,
    parameter int IW = 4,
    parameter int GW = 4
) (
    input  logic [IW-1:0] hazard,
    input  logic [DW-1:0] dcur,
    input  logic [DW-1:0] dnext,
    output logic [GW-1:0] gap
);

    logic [GW-1:0] drop_w;
    logic [GW-1:0] haz_w;

    assign drop_w = GW'(lsc_pkg::sat_sub(16'(dcur), 16'(dnext)));
    assign haz_w  = GW'(hazard);
    assign gap    = (haz_w > drop_w) ? haz_w : drop_w;

endmodule

// File: rtl/lsc_seq_fsm.sv
module lsc_seq_fsm
    import lsc_pkg::*;
#(
    parameter int NL = 4,
    parameter int MD = 6,
    parameter int DW = 3,
    parameter int IT = 4,
    parameter int GW = 4,
    localparam int LPW  = (NL > 1) ? $clog2(NL) : 1,
    localparam int BPW  = (MD > 1) ? $clog2(MD) : 1,
    localparam int NLW  = $clog2(NL + 1),
    localparam int CWID = ((BPW > DW) ? BPW : DW) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [DW-1:0]  cur_degree,
    input  logic [GW-1:0]  gap,
    input  logic [NLW-1:0] num_layers,
    input  logic [IT-1:0]  num_iters,
    output sched_state_e   state,
    output logic [LPW-1:0] cur_ptr,
    output logic [LPW-1:0] nxt_ptr,
    output logic [BPW-1:0] blk_ptr,
    output logic [IT-1:0]  iter,
    output logic           done,
    output logic           load,
    output logic           blk_end
);

    logic [GW-1:0] idle_q;
    logic          last_layer;
    logic          last_iter;
    logic          final_blk;

    assign last_layer = (NLW'(cur_ptr) == (num_layers - NLW'(1)));
    assign last_iter  = ((iter + IT'(1)) == num_iters);
    assign nxt_ptr    = last_layer ? '0 : (cur_ptr + LPW'(1));
    assign blk_end    = ((CWID'(blk_ptr) + CWID'(1)) == CWID'(cur_degree));
    assign final_blk  = blk_end && last_layer && last_iter;
    assign load       = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_ptr <= '0;
            blk_ptr <= '0;
            iter    <= '0;
            idle_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_READ;
                        cur_ptr <= '0;
                        blk_ptr <= '0;
                        iter    <= '0;
                    end
                end
                ST_READ: begin
                    if (final_blk) begin
                        state   <= ST_IDLE;
                        blk_ptr <= '0;
                        done    <= 1'b1;
                    end else if (blk_end) begin
                        blk_ptr <= '0;
                        cur_ptr <= nxt_ptr;
                        if (last_layer) iter <= iter + IT'(1);
                        if (gap != '0) begin
                            state  <= ST_STALL;
                            idle_q <= gap;
                        end
                    end else begin
                        blk_ptr <= blk_ptr + BPW'(1);
                    end
                end
                ST_STALL: begin
                    if (idle_q == GW'(1)) state <= ST_READ;
                    idle_q <= idle_q - GW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the block pointer never reaches the degree while reading
    assert_blk_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ) |-> (CWID'(blk_ptr) < CWID'(cur_degree)));

    // R3: zero gap means the next layer starts on the following cycle
    assert_back_to_back_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ && blk_end && !final_blk && gap == '0)
        |=> (state == ST_READ && blk_ptr == '0));

    // R4: a nonzero gap moves into the stall state
    assert_enter_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ && blk_end && !final_blk && gap != '0) |=> (state == ST_STALL));

    // R6: the iteration count only moves when the sequence wraps to slot 0
    assert_iter_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE && iter != $past(iter)) |-> (cur_ptr == '0));

    // R7: done is a single-cycle pulse seen while idle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_IDLE) ##1 !done);

endmodule

// File: rtl/layer_sched_ctrl.sv
module layer_sched_ctrl
    import lsc_pkg::*;
#(
    parameter int NL = 4,
    parameter int MD = 6,
    parameter int CW = 5,
    parameter int LW = 3,
    parameter int DW = 3,
    parameter int IW = 4,
    parameter int IT = 4,
    localparam int LPW = (NL > 1) ? $clog2(NL) : 1,
    localparam int BPW = (MD > 1) ? $clog2(MD) : 1,
    localparam int NLW = $clog2(NL + 1),
    localparam int GW  = (IW > DW) ? IW : DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [NLW-1:0]      cfg_nlayers,
    input  logic [IT-1:0]       cfg_iters,
    input  logic [NL*LW-1:0]    cfg_index,
    input  logic [NL*DW-1:0]    cfg_degree,
    input  logic [NL*IW-1:0]    cfg_hazard,
    input  logic [NL*MD*CW-1:0] cfg_cols,
    output logic                rd_valid,
    output logic [CW-1:0]       rd_addr,
    output logic [LW-1:0]       rd_layer,
    output logic                rd_last,
    output logic                np_stall,
    output logic                busy,
    output logic [IT-1:0]       iter_cnt,
    output logic                done
);

    sched_state_e   state;
    logic [LPW-1:0] cur_ptr, nxt_ptr;
    logic [BPW-1:0] blk_ptr;
    logic [DW-1:0]  cur_degree, nxt_degree;
    logic [IW-1:0]  cur_hazard;
    logic [GW-1:0]  gap;
    logic [NLW-1:0] num_layers;
    logic [IT-1:0]  num_iters;
    logic           load, blk_end;

    lsc_cfg_table #(.NL(NL), .MD(MD), .CW(CW), .LW(LW), .DW(DW), .IW(IW), .IT(IT)) u_table (
        .clk(clk), .rst(rst), .load(load),
        .cfg_nlayers(cfg_nlayers), .cfg_iters(cfg_iters),
        .cfg_index(cfg_index), .cfg_degree(cfg_degree),
        .cfg_hazard(cfg_hazard), .cfg_cols(cfg_cols),
        .cur_ptr(cur_ptr), .nxt_ptr(nxt_ptr), .blk_ptr(blk_ptr),
        .cur_index(rd_layer), .cur_degree(cur_degree), .cur_hazard(cur_hazard),
        .cur_col(rd_addr), .nxt_degree(nxt_degree),
        .num_layers(num_layers), .num_iters(num_iters)
    );

    lsc_gap_calc #(.DW(DW), .IW(IW), .GW(GW)) u_gap (
        .hazard(cur_hazard), .dcur(cur_degree), .dnext(nxt_degree), .gap(gap)
    );

    lsc_seq_fsm #(.NL(NL), .MD(MD), .DW(DW), .IT(IT), .GW(GW)) u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .cur_degree(cur_degree), .gap(gap),
        .num_layers(num_layers), .num_iters(num_iters),
        .state(state), .cur_ptr(cur_ptr), .nxt_ptr(nxt_ptr), .blk_ptr(blk_ptr),
        .iter(iter_cnt), .done(done), .load(load), .blk_end(blk_end)
    );

    assign rd_valid = (state == ST_READ);
    assign np_stall = (state == ST_STALL);
    assign busy     = (state != ST_IDLE);
    assign rd_last  = rd_valid && blk_end;

    // R4: the gap computed at a layer end covers the hazard count
    assert_gap_hazard_R4: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> (GW'(cur_hazard) <= gap));

    // R5: the gap computed at a layer end covers a degree drop
    assert_gap_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_last && cur_degree > nxt_degree) |-> (GW'(cur_degree - nxt_degree) <= gap));

    // R1: reset leaves the outputs quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && iter_cnt == '0));

endmodule

// File: tb/layer_sched_ctrl_test.sv
module layer_sched_ctrl_test;

    localparam int NL = 4, MD = 6, CW = 5, LW = 3, DW = 3, IW = 4, IT = 4;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [2:0]          cfg_nlayers = '0;
    logic [IT-1:0]       cfg_iters = '0;
    logic [NL*LW-1:0]    cfg_index = '0;
    logic [NL*DW-1:0]    cfg_degree = '0;
    logic [NL*IW-1:0]    cfg_hazard = '0;
    logic [NL*MD*CW-1:0] cfg_cols = '0;
    logic rd_valid, rd_last, np_stall, busy, done;
    logic [CW-1:0] rd_addr;
    logic [LW-1:0] rd_layer;
    logic [IT-1:0] iter_cnt;

    int n_checks = 0, n_fail = 0;

    int t_n, t_it;
    int t_idx[NL], t_deg[NL], t_haz[NL];
    int t_col[NL][MD];

    int e_n;
    int e_v[512], e_s[512], e_b[512], e_d[512], e_a[512], e_l[512], e_last[512], e_it[512];

    always #2 clk = ~clk;

    layer_sched_ctrl uut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_nlayers(cfg_nlayers), .cfg_iters(cfg_iters),
        .cfg_index(cfg_index), .cfg_degree(cfg_degree),
        .cfg_hazard(cfg_hazard), .cfg_cols(cfg_cols),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_layer(rd_layer), .rd_last(rd_last),
        .np_stall(np_stall), .busy(busy), .iter_cnt(iter_cnt), .done(done)
    );

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish (got hang, expected summary)");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic check(string tag, bit ok, string what, int got, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic fill_slot(int k, int idx, int deg, int haz, int seed);
        t_idx[k] = idx;
        t_deg[k] = deg;
        t_haz[k] = haz;
        for (int j = 0; j < MD; j++) t_col[k][j] = (k * 7 + j * 3 + seed) % 32;
    endtask

    task automatic pack_cfg();
        cfg_nlayers = 3'(t_n);
        cfg_iters   = IT'(t_it);
        for (int k = 0; k < NL; k++) begin
            cfg_index[k*LW +: LW]  = LW'(t_idx[k]);
            cfg_degree[k*DW +: DW] = DW'(t_deg[k]);
            cfg_hazard[k*IW +: IW] = IW'(t_haz[k]);
            for (int j = 0; j < MD; j++) cfg_cols[(k*MD + j)*CW +: CW] = CW'(t_col[k][j]);
        end
    endtask

    task automatic push(int v, int s, int b, int d, int a, int l, int last, int it);
        e_v[e_n] = v; e_s[e_n] = s; e_b[e_n] = b; e_d[e_n] = d;
        e_a[e_n] = a; e_l[e_n] = l; e_last[e_n] = last; e_it[e_n] = it;
        e_n++;
    endtask

    // expected stream derived from the requirements
    task automatic build_expected();
        e_n = 0;
        for (int it = 0; it < t_it; it++) begin
            for (int l = 0; l < t_n; l++) begin
                for (int b = 0; b < t_deg[l]; b++)
                    push(1, 0, 1, 0, t_col[l][b], t_idx[l], (b == t_deg[l] - 1) ? 1 : 0, it);
                if (!(l == t_n - 1 && it == t_it - 1)) begin
                    int nx, drop, g;
                    nx = (l == t_n - 1) ? 0 : l + 1;
                    drop = (t_deg[l] > t_deg[nx]) ? t_deg[l] - t_deg[nx] : 0;
                    g = (t_haz[l] > drop) ? t_haz[l] : drop;
                    for (int c = 0; c < g; c++)
                        push(0, 1, 1, 0, 0, 0, 0, (l == t_n - 1) ? it + 1 : it);
                end
            end
        end
        push(0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic check_entry(string tag, int i);
        bit ok;
        ok = (int'(rd_valid) == e_v[i]) && (int'(np_stall) == e_s[i]) &&
             (int'(busy) == e_b[i]) && (int'(done) == e_d[i]);
        if (e_v[i] != 0)
            ok = ok && (int'(rd_addr) == e_a[i]) && (int'(rd_layer) == e_l[i]) &&
                 (int'(rd_last) == e_last[i]) && (int'(iter_cnt) == e_it[i]);
        if (e_s[i] != 0)
            ok = ok && (int'(iter_cnt) == e_it[i]);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: v/s/b/d/addr/layer/last/iter got %0d/%0d/%0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d/%0d/%0d",
                     tag, i, rd_valid, np_stall, busy, done, rd_addr, rd_layer, rd_last, iter_cnt,
                     e_v[i], e_s[i], e_b[i], e_d[i], e_a[i], e_l[i], e_last[i], e_it[i]);
        end
    endtask

    // start a run and compare every cycle; ign_at >= 0 pulses start mid-run
    task automatic run_check(string tag, int ign_at);
        pack_cfg();
        build_expected();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < e_n; i++) begin
            check_entry(tag, i);
            if (i == ign_at) begin
                start = 1'b1;
                cfg_degree = ~cfg_degree;
                cfg_cols = ~cfg_cols;
                cfg_hazard = ~cfg_hazard;
                cfg_nlayers = 3'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check("R7", !done && !busy, "done after pulse / busy", {30'd0, done, busy}, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1", !busy && !rd_valid && !np_stall && !done, "idle outputs after reset",
              {28'd0, busy, rd_valid, np_stall, done}, 0);
        check("R1", iter_cnt == '0, "iter_cnt after reset", int'(iter_cnt), 0);
        t_n = 2; t_it = 3;
        fill_slot(0, 1, 3, 2, 4);
        fill_slot(1, 2, 3, 1, 4);
        pack_cfg();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (9) @(negedge clk);
        check("R1", busy, "busy mid-run before reset", int'(busy), 1);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1", !busy && !rd_valid && !np_stall && !done, "outputs after mid-run reset",
              {28'd0, busy, rd_valid, np_stall, done}, 0);
        check("R1", iter_cnt == '0, "iter_cnt after mid-run reset", int'(iter_cnt), 0);
    endtask

    task automatic test_back_to_back();
        t_n = 3; t_it = 2;
        fill_slot(0, 5, 3, 0, 1);
        fill_slot(1, 2, 3, 0, 1);
        fill_slot(2, 7, 3, 0, 1);
        fill_slot(3, 0, 1, 0, 1);
        run_check("R3", -1);
    endtask

    task automatic test_hazard();
        t_n = 3; t_it = 2;
        fill_slot(0, 3, 4, 2, 9);
        fill_slot(1, 0, 4, 0, 9);
        fill_slot(2, 6, 4, 3, 9);
        run_check("R4", -1);
    endtask

    task automatic test_degree_drop();
        t_n = 4; t_it = 2;
        fill_slot(0, 1, 5, 1, 13);
        fill_slot(1, 4, 2, 0, 13);
        fill_slot(2, 2, 4, 0, 13);
        fill_slot(3, 6, 6, 2, 13);
        run_check("R5", -1);
    endtask

    task automatic test_wrap();
        t_n = 2; t_it = 3;
        fill_slot(0, 2, 2, 0, 20);
        fill_slot(1, 5, 6, 1, 20);
        run_check("R6", -1);
    endtask

    task automatic test_ignore_start();
        t_n = 3; t_it = 2;
        fill_slot(0, 1, 4, 1, 5);
        fill_slot(1, 3, 2, 2, 5);
        fill_slot(2, 5, 3, 0, 5);
        run_check("R8", 4);
    endtask

    task automatic test_single_slot();
        t_n = 1; t_it = 1;
        fill_slot(0, 4, 5, 3, 17);
        run_check("R9", -1);
        t_it = 3;
        run_check("R9", -1);
    endtask

    task automatic test_full_degree();
        t_n = 4; t_it = 1;
        fill_slot(0, 0, 6, 0, 2);
        fill_slot(1, 1, 6, 0, 2);
        fill_slot(2, 2, 1, 0, 2);
        fill_slot(3, 3, 6, 0, 2);
        run_check("R2", -1);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        test_reset();
        test_full_degree();
        test_back_to_back();
        test_hazard();
        test_degree_drop();
        test_wrap();
        test_ignore_start();
        test_single_slot();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule